// File: doc/BRIEF.md
# I2C Bus Clock Divider

This block turns the core clock into the timing strobes that a bit-level I2C engine needs. Software programs one 8-bit factor register. The register holds a 3-bit exponent factor N and a 4-bit linear factor M. Two cascaded counters divide the core clock, first by (M+1) and then by a power of two. The result is a one-cycle sampling tick. A further stage groups the sampling ticks in fives and produces an SCL phase level and a toggle strobe. One SCL period therefore spans ten sampling ticks.

An exponent-mode input selects how N is applied. With the input low, the power-of-two stage divides by 2^(N+1). With the input high, it divides by 2^N. Software searches for the best factor pair itself and writes the result. A write to the soft-reset address, whatever the data, returns the divider to its power-up state. Software then rewrites the factor register. A new factor pair or exponent mode is adopted only at the end of the current tick period, so the engine never sees a shortened period.

Top module: `i2c_busclk_div`

## Requirements
- R1: A write to address 1 loads N from wr_data[2:0] and M from wr_data[6:3]; wr_data[7] has no effect.
- R2: With the adopted exponent mode 0, sample_tick rises once every (M+1)·2^(N+1) core cycles.
- R3: With the adopted exponent mode 1, sample_tick rises once every (M+1)·2^N core cycles.
- R4: sample_tick is high for exactly one cycle whenever the period is longer than one cycle. With M=0, N=0 and mode 1 it is high on every cycle.
- R5: scl_phase changes level once every 5 sampling ticks, giving 5 ticks low and 5 ticks high. scl_toggle is high, together with sample_tick, in the cycle where the new level first appears.
- R6: A new M/N value and the alt_exp level are adopted only at a terminal count. The tick interval in which the write falls keeps the old length.
- R7: A write of any data to address 2 clears, in one cycle, the counters, both factor copies, the adopted mode and the phase logic. The next tick then comes on the second cycle after the clear cycle, and after that every 2 cycles. The first phase change comes on the fifth tick.
- R8: After reset all three outputs are low and the factors are zero in mode 0. The first tick comes in the second cycle after reset is released.
- R9: Writes to addresses 0 and 3 change neither the factors nor the period.
- R10: The largest setting, M=15 and N=7 in mode 0, gives a period of 4096 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 2 | Write address: 1 = factor register, 2 = soft reset |
| wr_data | input | 8 | Write data |
| alt_exp | input | 1 | Exponent mode: 0 gives 2^(N+1), 1 gives 2^N |
| sample_tick | output | 1 | One-cycle sampling enable |
| scl_toggle | output | 1 | Strobe in the cycle where scl_phase takes its new level |
| scl_phase | output | 1 | SCL-rate level: 5 ticks low, then 5 ticks high |

## Verification
The assertions assume that the factor address and the soft-reset address are distinct. They also assume that wr_en is a plain strobe that carries one address per cycle. Under those assumptions the active factors can change only on a terminal count or a clear, and the two counters never exceed their limits.

The stimulus drives every write and every change of alt_exp at the falling edge of the clock, one cycle at a time. Some writes and mode changes fall in the middle of a period on purpose. After a write, the checks on period length wait for two whole tick boundaries before measuring.

// File: rtl/i2cdiv_pkg.sv
// Shared field layout and types for the I2C bus clock divider.
// Assumes the factor register keeps N in its low bits and M directly above.
package i2cdiv_pkg;
    localparam int N_W   = 3;                 // exponent factor width
    localparam int M_W   = 4;                 // linear factor width
    localparam int REG_W = 8;                 // register data width
    localparam int N_LSB = 0;
    localparam int M_LSB = N_LSB + N_W;
    localparam int EXP_W = N_W + 1;           // holds 0 .. 2^N_W
    localparam int P2_W  = 1 << N_W;          // counter bits for 2^(max exponent)

    typedef struct packed {
        logic [M_W-1:0] m;
        logic [N_W-1:0] n;
        logic           alt;
    } div_cfg_t;

    // Exponent applied by the power-of-two stage for a given configuration.
    function automatic logic [EXP_W-1:0] exp_of(div_cfg_t c);
        logic [EXP_W-1:0] e;
        e = EXP_W'(c.n);
        if (!c.alt) e = e + EXP_W'(1);
        return e;
    endfunction
endpackage

// File: rtl/i2cdiv_regs.sv
// Factor register decode and active-copy holding for the bus divider.
// A write to DIV_ADDR updates a shadow copy. The shadow copy, together with
// the exponent-mode pin, moves into the active copy only on commit (a
// terminal count). A write to SRST_ADDR clears everything. Assumes
// DIV_ADDR != SRST_ADDR.
module i2cdiv_regs
    import i2cdiv_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter logic [ADDR_W-1:0] DIV_ADDR  = ADDR_W'(1),
    parameter logic [ADDR_W-1:0] SRST_ADDR = ADDR_W'(2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              alt_mode,
    input  logic              commit,
    output logic              clr,
    output div_cfg_t          cfg_act
);
    logic [M_W-1:0] m_sh;
    logic [N_W-1:0] n_sh;
    logic           div_wr;
    logic           unused_hi;

    assign clr       = wr_en && (wr_addr == SRST_ADDR);
    assign div_wr    = wr_en && (wr_addr == DIV_ADDR);
    assign unused_hi = ^wr_data[REG_W-1:M_LSB+M_W];

    // Shadow copy: captures the factor fields of each register write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            m_sh <= '0;
            n_sh <= '0;
        end else if (div_wr) begin
            m_sh <= wr_data[M_LSB +: M_W];
            n_sh <= wr_data[N_LSB +: N_W];
        end
    end

    // Active copy: adopts shadow and mode only at a terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cfg_act <= '0;
        end else if (commit) begin
            cfg_act <= '{m: m_sh, n: n_sh, alt: alt_mode};
        end
    end

    assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !clr) |=> $stable(cfg_act));

    assert_other_addr_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != DIV_ADDR && wr_addr != SRST_ADDR)
            |=> ($stable(m_sh) && $stable(n_sh)));
endmodule

// File: rtl/i2cdiv_lin.sv
// Linear prescaler: counts 0..lim and flags the wrap cycle (divide by lim+1).
// Assumes lim changes only in a cycle where wrap is high, or on clr.
module i2cdiv_lin #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] lim,
    output logic         wrap
);
    logic [W-1:0] cnt;

    assign wrap = (cnt == lim);

    // Count up and restart after the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (wrap)     cnt <= '0;
        else               cnt <= cnt + W'(1);
    end

    assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= lim);
endmodule

// File: rtl/i2cdiv_pow2.sv
// Power-of-two stage: counts prescaler steps and raises term on the last step
// of each 2^exp_sel group. Assumes exp_sel <= CW and that exp_sel changes only
// in a term cycle or on clr.
module i2cdiv_pow2 #(
    parameter int CW = 8,
    parameter int EW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic [EW-1:0] exp_sel,
    output logic          term
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] mask;

    // Terminal mask: the low exp_sel bits are set.
    for (genvar i = 0; i < CW; i++) begin : g_mask
        assign mask[i] = (EW'(i) < exp_sel);
    end

    assign term = step && (cnt == mask);

    // Advance once per prescaler wrap and restart on the terminal step.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (term)     cnt <= '0;
        else if (step)     cnt <= cnt + CW'(1);
    end

    assert_pow2_in_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= mask);
endmodule

// File: rtl/i2cdiv_phase.sv
// Output stage: registers the sampling tick and groups ticks into SCL half
// periods of OVS/2 ticks each. Assumes OVS is even and at least 2.
module i2cdiv_phase #(
    parameter int OVS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic term,
    output logic sample_tick,
    output logic scl_toggle,
    output logic scl_phase
);
    localparam int HALF = OVS / 2;
    localparam int PW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [PW-1:0] ph_cnt;
    logic          half_end;

    assign half_end = (ph_cnt == PW'(HALF - 1));

    // Register the tick and step the half-period counter on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sample_tick <= 1'b0;
            scl_toggle  <= 1'b0;
            scl_phase   <= 1'b0;
            ph_cnt      <= '0;
        end else begin
            sample_tick <= term;
            scl_toggle  <= term && half_end;
            if (term) begin
                if (half_end) begin
                    ph_cnt    <= '0;
                    scl_phase <= ~scl_phase;
                end else begin
                    ph_cnt <= ph_cnt + PW'(1);
                end
            end
        end
    end

    assert_toggle_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        scl_toggle |-> sample_tick);

    assert_phase_cnt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ph_cnt < PW'(HALF));

    assert_phase_moves_on_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(scl_phase) |-> (scl_toggle || $past(clr)));
endmodule

// File: rtl/i2c_busclk_div.sv
// I2C bus clock divider top. Cascades a linear (M+1) prescaler with a
// 2^exp stage to make the sampling tick, then groups ticks into SCL halves.
// Factor and mode changes take effect at the terminal count.
// Assumes a single write per cycle and distinct register addresses.
module i2c_busclk_div
    import i2cdiv_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter logic [ADDR_W-1:0] DIV_ADDR  = ADDR_W'(1),
    parameter logic [ADDR_W-1:0] SRST_ADDR = ADDR_W'(2),
    parameter int OVS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              alt_exp,
    output logic              sample_tick,
    output logic              scl_toggle,
    output logic              scl_phase
);
    logic             clr;
    logic             wrap;
    logic             term;
    div_cfg_t         cfg_act;
    logic [EXP_W-1:0] exp_sel;

    assign exp_sel = exp_of(cfg_act);

    i2cdiv_regs #(.ADDR_W(ADDR_W), .DIV_ADDR(DIV_ADDR), .SRST_ADDR(SRST_ADDR)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .alt_mode(alt_exp), .commit(term),
        .clr(clr), .cfg_act(cfg_act)
    );

    i2cdiv_lin #(.W(M_W)) u_lin (
        .clk(clk), .rst_n(rst_n), .clr(clr), .lim(cfg_act.m), .wrap(wrap)
    );

    i2cdiv_pow2 #(.CW(P2_W), .EW(EXP_W)) u_pow2 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .step(wrap),
        .exp_sel(exp_sel), .term(term)
    );

    i2cdiv_phase #(.OVS(OVS)) u_phase (
        .clk(clk), .rst_n(rst_n), .clr(clr), .term(term),
        .sample_tick(sample_tick), .scl_toggle(scl_toggle), .scl_phase(scl_phase)
    );
endmodule

// File: tb/sim_i2c_busclk_div.sv
`timescale 1ns/1ps
module sim_i2c_busclk_div;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [1:0] wr_addr;
    logic [7:0] wr_data;
    logic       alt_exp;
    logic       sample_tick, scl_toggle, scl_phase;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [1:0] A_DIV  = 2'd1;
    localparam logic [1:0] A_SRST = 2'd2;

    typedef struct packed {
        logic       alt;
        logic [3:0] m;
        logic [2:0] n;
        int         per;
    } vec_t;

    // Periods worked out by hand from R2/R3: (M+1) * 2^(N+1) or (M+1) * 2^N.
    localparam vec_t VECS [8] = '{
        '{alt: 1'b0, m: 4'd0,  n: 3'd0, per: 2},
        '{alt: 1'b0, m: 4'd3,  n: 3'd1, per: 16},
        '{alt: 1'b0, m: 4'd2,  n: 3'd2, per: 24},
        '{alt: 1'b1, m: 4'd0,  n: 3'd3, per: 8},
        '{alt: 1'b1, m: 4'd4,  n: 3'd0, per: 5},
        '{alt: 1'b1, m: 4'd1,  n: 3'd2, per: 8},
        '{alt: 1'b0, m: 4'd15, n: 3'd7, per: 4096},
        '{alt: 1'b1, m: 4'd0,  n: 3'd0, per: 1}
    };

    always #4 clk = ~clk;

    i2c_busclk_div u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .alt_exp(alt_exp), .sample_tick(sample_tick),
        .scl_toggle(scl_toggle), .scl_phase(scl_phase)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One-cycle register write, driven from a falling edge.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 2'd0; wr_data = 8'd0;
    endtask

    task automatic next_tick();
        do @(negedge clk); while (!sample_tick);
    endtask

    // Called at a tick; returns the cycles to the following tick.
    task automatic measure(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!sample_tick);
    endtask

    task automatic program_cfg(input logic alt, input logic [7:0] d);
        alt_exp = alt;
        wr(A_DIV, d);
        next_tick();
        next_tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        string lbl;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = 2'd0; wr_data = 8'd0; alt_exp = 1'b0;
        repeat (4) @(negedge clk);
        check("R8 outputs low in reset", {29'd0, sample_tick, scl_toggle, scl_phase}, 0);
        rst_n = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!sample_tick && n < 50);
        check("R8 first tick after release", n, 2);
        measure(n);
        check("R8 zero factors give period 2", n, 2);

        // Vector table: period for each mode/factor pair.
        for (int i = 0; i < 8; i++) begin
            program_cfg(VECS[i].alt, {1'b0, VECS[i].m, VECS[i].n});
            measure(n);
            lbl = VECS[i].alt ? "R3 period" : "R2 period";
            if (VECS[i].per == 4096) lbl = "R10 max period";
            if (VECS[i].per == 1)    lbl = "R4 every-cycle period";
            check(lbl, n, VECS[i].per);
            @(negedge clk);
            check("R4 tick width", int'(sample_tick), (VECS[i].per == 1) ? 1 : 0);
        end

        // R9: writes to unused addresses leave the period unchanged.
        program_cfg(1'b0, 8'b0_0010_001);   // M=2, N=1 -> 12
        wr(2'd3, 8'h7F);
        wr(2'd0, 8'h00);
        next_tick(); next_tick();
        measure(n);
        check("R9 unused address ignored", n, 12);

        // R1: bit 7 has no effect; M=1, N=3, mode 0 -> 2*16.
        program_cfg(1'b0, 8'h8B);
        measure(n);
        check("R1 field decode with bit7 set", n, 32);

        // R6: a mid-period write and mode change keep the current interval.
        n = 0;
        repeat (5) begin @(negedge clk); n++; end
        alt_exp = 1'b1;
        wr_en = 1'b1; wr_addr = A_DIV; wr_data = 8'b0_0000_010;   // M=0, N=2
        @(negedge clk); n++;
        wr_en = 1'b0; wr_addr = 2'd0; wr_data = 8'd0;
        while (!sample_tick) begin @(negedge clk); n++; end
        check("R6 interval spanning write keeps old length", n, 32);
        measure(n);
        check("R6 new factors after boundary", n, 4);

        // R5: half periods of 5 ticks, 20 cycles at period 4.
        do @(negedge clk); while (!scl_toggle);
        for (int h = 0; h < 2; h++) begin
            int ticks, cyc, moved;
            logic p;
            p = scl_phase; ticks = 0; cyc = 0; moved = 0;
            do begin
                @(negedge clk); cyc++;
                if (sample_tick) ticks++;
                if (!scl_toggle && scl_phase != p) moved++;
            end while (!scl_toggle);
            check("R5 ticks per half period", ticks, 5);
            check("R5 cycles per half period", cyc, 20);
            check("R5 phase flips on toggle", int'(scl_phase), int'(!p));
            check("R5 phase steady within half", moved, 0);
            check("R5 toggle with tick", int'(sample_tick), 1);
        end

        // R7: soft reset with arbitrary data.
        program_cfg(1'b0, 8'b0_0011_001);   // M=3, N=1 -> 16
        repeat (3) @(negedge clk);
        wr(A_SRST, 8'hA5);
        check("R7 outputs cleared", {30'd0, sample_tick, scl_phase}, 0);
        n = 0;
        do begin @(negedge clk); n++; end while (!sample_tick && n < 50);
        check("R7 first tick after clear", n, 2);
        begin
            int ticks;
            ticks = 1;
            while (!scl_toggle && ticks < 20) begin
                @(negedge clk);
                if (sample_tick) ticks++;
            end
            check("R7 phase restart at fifth tick", ticks, 5);
            check("R7 phase high after first toggle", int'(scl_phase), 1);
        end
        measure(n);
        check("R7 factors cleared to zero", n, 2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule